// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one 8-bit output compare channel that sits beside a timer counter. The counter lives outside the block. Its value, a per-cycle tick enable, top and bottom markers and the waveform mode all arrive as inputs. The CPU writes the compare value through a write strobe and a data bus. On each timer tick the channel compares that value with the counter. A real match raises a sticky interrupt flag and moves the waveform pin: it can hold, toggle, clear or set the pin.

In the two pulse-width modes the compare value is double-buffered. A CPU write goes into a shadow register, and the shadow is copied into the live compare register only on a tick at the end of the count sequence, so a pulse never gets an odd length. In the two plain modes a write goes straight to the live register. In the plain modes the CPU can also use a force strobe to move the pin as if a match had happened. A forced match leaves the flag alone.

When the CPU writes the counter, it reports this through a strobe. The channel then masks any match on the next timer tick, however many idle cycles pass before that tick arrives. This lets software preload equal counter and compare values without raising a spurious interrupt.

Top module: `tmr_ocu`

## Requirements
- R1: After reset, `cmp_flag`, `wave_out`, the live compare register and the shadow register are all zero. A match is a cycle with `tick` high, no pending block, and `cnt` equal to the live compare register. A match sets `cmp_flag` from the next clock edge onward.
- R2: `flag_clr` high clears `cmp_flag` at the next edge. When a match happens in the same cycle, the set wins.
- R3: In a plain mode, `cmp_wr` loads `cmp_wdata` into the live register at the next edge. From that edge `cmp_rdata` returns the live register.
- R4: In a pulse-width mode, `cmp_wr` loads only the shadow register, and `cmp_rdata` returns the shadow. On a tick where the chosen end marker is high, the shadow is copied into the live register. `load_at_top`=1 chooses `at_top` and 0 chooses `at_bottom`. At any other time the live register keeps its value.
- R5: `out_mode` picks what a match or force does to `wave_out`: 00 leaves it unchanged, 01 toggles it, 10 drives 0 and 11 drives 1. The new level appears at the next edge.
- R6: In a plain mode, `force_cmp` applies the `out_mode` action to `wave_out` without touching `cmp_flag`. In a pulse-width mode `force_cmp` has no effect.
- R7: A `cnt_wr` pulse blocks the match on the next cycle that has `tick` high, even after idle cycles with no tick. That tick clears the block.
- R8: `wave_mode` bit 0 selects the buffering: 00 (normal) and 10 (clear-on-compare) are plain modes, and 01 and 11 are pulse-width modes.
- R9: Nothing matches in a cycle where `tick` is low, even when `cnt` equals the live register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_wr | input | 1 | CPU write strobe for the compare value |
| cmp_wdata | input | 8 | CPU write data |
| cmp_rdata | output | 8 | CPU read of the compare value (shadow in pulse-width modes) |
| cnt_wr | input | 1 | Strobe: the CPU wrote the counter this cycle |
| force_cmp | input | 1 | Force-compare strobe |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| tick | input | 1 | Timer tick enable |
| cnt | input | 8 | Current counter value |
| at_top | input | 1 | Counter is at the top of its sequence |
| at_bottom | input | 1 | Counter is at the bottom of its sequence |
| wave_mode | input | 2 | Waveform generation mode |
| load_at_top | input | 1 | Shadow copy point: 1 = top, 0 = bottom |
| out_mode | input | 2 | Pin action on a match or force |
| wave_out | output | 1 | Waveform output pin |
| cmp_flag | output | 1 | Compare match flag (interrupt request) |

## Verification
The hardest case to reach is a counter write that lands while the timer is stalled, followed by several idle cycles and then a tick whose count equals the compare value. The block has to remember the mask across those idle cycles and drop it after that single tick. Directed sequences build this case, and also the case where a shadow write and a copy tick fall in the same cycle. Random stimulus keeps the counter and compare values in a small range so that matches, blocks, forces and flag clears collide often.

// File: rtl/tmr_ocu_pkg.sv
package tmr_ocu_pkg;

  typedef enum logic [1:0] {
    OM_HOLD   = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } out_mode_e;

  // Pin level after a match or force event (R5).
  function automatic logic next_level(logic [1:0] mode, logic cur);
    case (out_mode_e'(mode))
      OM_TOGGLE: return ~cur;
      OM_CLEAR:  return 1'b0;
      OM_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction

  // Pulse-width modes have bit 0 set (R8).
  function automatic logic is_pwm(logic [1:0] wm);
    return wm[0];
  endfunction

endpackage

// File: rtl/ocu_cmp_reg.sv
module ocu_cmp_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwm,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         tick,
  input  logic         at_top,
  input  logic         at_bottom,
  input  logic         load_at_top,
  output logic [W-1:0] active,
  output logic [W-1:0] shadow,
  output logic         load_evt
);
  logic direct_wr;

  assign direct_wr = wr && !pwm;
  assign load_evt  = pwm && tick && (load_at_top ? at_top : at_bottom);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
      shadow <= '0;
    end else begin
      if (wr)            shadow <= wdata;
      if (direct_wr)     active <= wdata;
      else if (load_evt) active <= shadow;
    end
  end

  a_r3_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !pwm) |=> (active == $past(wdata)));

  a_r4_live_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !tick) |=> $stable(active));

  a_r4_shadow_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && tick && load_at_top && at_top) |=> (active == $past(shadow)));

endmodule

// File: rtl/ocu_match.sv
module ocu_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] active,
  input  logic         cnt_wr,
  output logic         match,
  output logic         blocked
);
  logic equal;

  assign equal = (cnt == active);
  assign match = tick && equal && !blocked;

  // The block stays armed until a tick consumes it (R7).
  always_ff @(posedge clk) begin
    if (!rst_n)      blocked <= 1'b0;
    else if (cnt_wr) blocked <= 1'b1;
    else if (tick)   blocked <= 1'b0;
  end

  a_r7_armed: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> blocked);

  a_r7_released: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> !blocked);

endmodule

// File: rtl/ocu_wave.sv
module ocu_wave
  import tmr_ocu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       match,
  input  logic       force_evt,
  input  logic [1:0] out_mode,
  input  logic       flag_clr,
  output logic       wave_out,
  output logic       cmp_flag
);
  logic pin_evt;

  assign pin_evt = match || force_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_out <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (pin_evt)       wave_out <= next_level(out_mode, wave_out);
      if (match)         cmp_flag <= 1'b1;
      else if (flag_clr) cmp_flag <= 1'b0;
    end
  end

  a_r1_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> cmp_flag);

  a_r2_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match) |=> !cmp_flag);

  a_r6_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (force_evt && !match && !flag_clr) |=> (cmp_flag == $past(cmp_flag)));

  a_r5_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_evt |=> $stable(wave_out));

endmodule

// File: rtl/tmr_ocu.sv
module tmr_ocu
  import tmr_ocu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] cmp_rdata,
  input  logic         cnt_wr,
  input  logic         force_cmp,
  input  logic         flag_clr,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         at_top,
  input  logic         at_bottom,
  input  logic [1:0]   wave_mode,
  input  logic         load_at_top,
  input  logic [1:0]   out_mode,
  output logic         wave_out,
  output logic         cmp_flag
);
  logic         pwm;
  logic [W-1:0] active;
  logic [W-1:0] shadow;
  logic         load_evt;
  logic         match;
  logic         blocked;
  logic         force_evt;

  assign pwm       = is_pwm(wave_mode);
  assign force_evt = force_cmp && !pwm;
  assign cmp_rdata = pwm ? shadow : active;

  ocu_cmp_reg #(.W(W)) u_reg (
    .clk(clk), .rst_n(rst_n), .pwm(pwm), .wr(cmp_wr), .wdata(cmp_wdata),
    .tick(tick), .at_top(at_top), .at_bottom(at_bottom),
    .load_at_top(load_at_top), .active(active), .shadow(shadow),
    .load_evt(load_evt)
  );

  ocu_match #(.W(W)) u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .active(active),
    .cnt_wr(cnt_wr), .match(match), .blocked(blocked)
  );

  ocu_wave u_wave (
    .clk(clk), .rst_n(rst_n), .match(match), .force_evt(force_evt),
    .out_mode(out_mode), .flag_clr(flag_clr), .wave_out(wave_out),
    .cmp_flag(cmp_flag)
  );

  a_r7_masked_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_wr) && tick) |-> !match);

  a_r9_no_tick_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !flag_clr) |=> (cmp_flag == $past(cmp_flag)));

  a_r6_pwm_force_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !tick) |=> $stable(wave_out));

endmodule

// File: tb/tmr_ocu_tb.sv
module tmr_ocu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_wr = 0, cnt_wr = 0, force_cmp = 0, flag_clr = 0, tick = 0;
  logic at_top = 0, at_bottom = 0, load_at_top = 0;
  logic [W-1:0] cmp_wdata = '0, cnt = '0;
  logic [1:0] wave_mode = 2'b00, out_mode = 2'b00;
  logic [W-1:0] cmp_rdata;
  logic wave_out, cmp_flag;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference model state
  logic [W-1:0] m_act = '0, m_buf = '0;
  logic m_out = 0, m_flag = 0, m_blk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_ocu #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .cmp_rdata(cmp_rdata), .cnt_wr(cnt_wr), .force_cmp(force_cmp),
    .flag_clr(flag_clr), .tick(tick), .cnt(cnt), .at_top(at_top),
    .at_bottom(at_bottom), .wave_mode(wave_mode), .load_at_top(load_at_top),
    .out_mode(out_mode), .wave_out(wave_out), .cmp_flag(cmp_flag)
  );

  function automatic logic pin_after(logic [1:0] om, logic lvl);
    if (om == 2'b00) return lvl;
    if (om == 2'b01) return !lvl;
    return om[0];
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One clock: model update after the edge, compare at the falling edge.
  task automatic cyc(string tag);
    logic pw, hit;
    @(posedge clk);
    pw  = wave_mode[0];
    hit = tick && (cnt == m_act) && !m_blk;
    if (hit || (force_cmp && !pw)) m_out = pin_after(out_mode, m_out);
    if (hit) m_flag = 1;
    else if (flag_clr) m_flag = 0;
    if (cmp_wr && !pw) m_act = cmp_wdata;
    else if (pw && tick && (load_at_top ? at_top : at_bottom)) m_act = m_buf;
    if (cmp_wr) m_buf = cmp_wdata;
    if (cnt_wr) m_blk = 1;
    else if (tick) m_blk = 0;
    @(negedge clk);
    cmp_wr = 0; cnt_wr = 0; force_cmp = 0; flag_clr = 0; tick = 0;
    at_top = 0; at_bottom = 0;
    check(tag, "cmp_flag", cmp_flag, m_flag);
    check(tag, "wave_out", wave_out, m_out);
    check(tag, "cmp_rdata", cmp_rdata, wave_mode[0] ? m_buf : m_act);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "flag rst", cmp_flag, 0);
    check("R1", "out rst", wave_out, 0);
    check("R1", "rdata rst", cmp_rdata, 0);
    rst_n = 1;

    // R3/R8: normal mode direct write, then R1 match with R5 set
    wave_mode = 2'b00; cmp_wr = 1; cmp_wdata = 8'd5; cyc("R3");
    out_mode = 2'b11; cnt = 8'd5; cyc("R9");          // no tick: no match
    tick = 1; cnt = 8'd5; cyc("R1");
    check("R1", "flag set", cmp_flag, 1);
    // R2: clear, and set wins over clear
    flag_clr = 1; cyc("R2");
    check("R2", "flag cleared", cmp_flag, 0);
    flag_clr = 1; tick = 1; cnt = 8'd5; cyc("R2");
    check("R2", "set wins", cmp_flag, 1);
    // R5: toggle / clear
    out_mode = 2'b01; tick = 1; cnt = 8'd5; cyc("R5");
    out_mode = 2'b10; tick = 1; cnt = 8'd5; cyc("R5");
    check("R5", "cleared pin", wave_out, 0);
    // R6: force in CTC mode, no flag
    flag_clr = 1; cyc("R6");
    wave_mode = 2'b10; out_mode = 2'b11; force_cmp = 1; cyc("R6");
    check("R6", "forced pin", wave_out, 1);
    check("R6", "force no flag", cmp_flag, 0);
    // R6: force ignored in PWM
    wave_mode = 2'b01; out_mode = 2'b01; force_cmp = 1; cyc("R6");
    check("R6", "pwm force ignored", wave_out, 1);
    // R7: counter write, idle, then matching tick is masked
    wave_mode = 2'b00; cnt_wr = 1; cyc("R7");
    cyc("R7"); cyc("R7");
    tick = 1; cnt = 8'd5; cyc("R7");
    check("R7", "masked", cmp_flag, 0);
    tick = 1; cnt = 8'd5; cyc("R7");
    check("R7", "unmasked", cmp_flag, 1);
    // R4/R8: PWM shadow write, copy at bottom, then at top
    flag_clr = 1; cyc("R2");
    wave_mode = 2'b11; load_at_top = 0; cmp_wr = 1; cmp_wdata = 8'd9; cyc("R4");
    check("R4", "shadow read", cmp_rdata, 9);
    tick = 1; at_top = 1; cnt = 8'd9; cyc("R4");     // wrong marker, no copy
    check("R4", "no copy flag", cmp_flag, 0);
    tick = 1; at_bottom = 1; cnt = 8'd0; cyc("R4");  // copy
    tick = 1; cnt = 8'd9; cyc("R4");
    check("R4", "copied match", cmp_flag, 1);
    load_at_top = 1; cmp_wr = 1; cmp_wdata = 8'd3;
    tick = 1; at_top = 1; cnt = 8'd0; cyc("R4");     // copy takes old shadow 9
    wave_mode = 2'b00; cyc("R8");
    check("R8", "live after copy", cmp_rdata, 9);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      wave_mode   = 2'($urandom);
      out_mode    = 2'($urandom);
      load_at_top = 1'($urandom);
      cmp_wr      = ($urandom % 6) == 0;
      cmp_wdata   = W'($urandom % 4);
      cnt_wr      = ($urandom % 8) == 0;
      force_cmp   = ($urandom % 6) == 0;
      flag_clr    = ($urandom % 4) == 0;
      tick        = ($urandom % 3) != 0;
      cnt         = W'($urandom % 4);
      at_top      = ($urandom % 4) == 0;
      at_bottom   = ($urandom % 4) == 0;
      cyc("R5");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule